// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recent page translations. Each one maps a virtual page number to a physical frame number. Every stored entry carries:

- a virtual page number,
- a valid flag,
- a modified (dirty) flag,
- two permission bits,
- a frame number,
- a process identifier.

A lookup compares the requested page against all entries in parallel. The hit, fault, frame and dirty results are registered and appear one cycle after the request.

When a lookup misses, the surrounding logic finds the translation elsewhere and installs it through the fill port. The block picks the slot itself. It uses the lowest free slot when one exists, and otherwise a rotating replacement pointer.

Entries can be tagged with a process identifier. With tagging on, translations of several address spaces can stay resident together. On a context switch, either a full invalidate or a per-process invalidate can be issued.

Top module: `xlat_cache`

## Requirements
- R1: A lookup (`lk_valid`=1) whose page matches a valid entry that permits the access returns, on the next clock edge, `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 and that entry's frame number on `rsp_pfn`. `rsp_valid` is 1 exactly in the cycles after a cycle with `lk_valid`=1.
- R2: A lookup that matches no valid entry returns `rsp_hit`=0, `rsp_fault`=0 and `rsp_pfn`=0. Without a response, `rsp_hit` and `rsp_fault` stay 0.
- R3: With `PID_EN`=1, a hit also requires the stored process ID to equal `lk_pid`. The same page under another ID misses.
- R4: Permission bit 0 allows reads and bit 1 allows writes. A matching access whose kind is not allowed returns `rsp_fault`=1, `rsp_hit`=0 and `rsp_pfn`=0. The entry is left unchanged, so a later allowed access still hits with its dirty flag clear.
- R5: A write hit sets the entry's modified flag. `rsp_dirty` reports the flag as it was before the access, so a following lookup of the same entry returns `rsp_dirty`=1. A fill clears the flag.
- R6: A fill (`fill_en`=1) writes the lowest-indexed invalid slot when any slot is invalid. The rotating pointer is not moved in that case.
- R7: When all slots are valid, a fill replaces the slot named by the rotating pointer and then advances the pointer by one, wrapping at `ENTRIES`. The pointer is 0 after reset.
- R8: `flush_en`=1 with `flush_by_pid`=0 invalidates every entry.
- R9: `flush_en`=1 with `flush_by_pid`=1 invalidates only entries whose process ID equals `flush_pid`.
- R10: A lookup sees the contents held before the same edge's updates. If a fill targets the slot that a same-cycle write hit would mark dirty, the fill wins: the new entry is clean. A fill in the same cycle as a flush also takes effect.
- R11: After reset every entry is invalid and `rsp_valid`, `rsp_hit` and `rsp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_pid | input | PID_W | Process ID of the request |
| lk_write | input | 1 | 1 = write access, 0 = read |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page of the new entry |
| fill_pid | input | PID_W | Process ID of the new entry |
| fill_pfn | input | PFN_W | Frame of the new entry |
| fill_prot | input | 2 | Permissions, bit0 read, bit1 write |
| flush_en | input | 1 | Invalidate request |
| flush_by_pid | input | 1 | 1 = only entries of `flush_pid` |
| flush_pid | input | PID_W | Process ID to invalidate |
| rsp_valid | output | 1 | Registered response present |
| rsp_hit | output | 1 | Translation found and allowed |
| rsp_fault | output | 1 | Translation found, access forbidden |
| rsp_pfn | output | PFN_W | Frame number on hit, else 0 |
| rsp_dirty | output | 1 | Modified flag of the hit entry before access |

## Verification
The checks assume the surrounding logic never installs a page and process pair that is already resident. Under that assumption at most one entry matches a lookup. The stimulus therefore fills only pages that are absent, and it refills a page only after its old copy has been evicted or flushed. The checks also take the flush and fill inputs as meaningful only after reset is released, and the bench drives them only then.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int PID_W   = 8,
  parameter bit PID_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_write,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [1:0]       fill_prot,
  input  logic             flush_en,
  input  logic             flush_by_pid,
  input  logic [PID_W-1:0] flush_pid,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_dirty
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [VPN_W-1:0] e_vpn  [ENTRIES];
  logic [PFN_W-1:0] e_pfn  [ENTRIES];
  logic [PID_W-1:0] e_pid  [ENTRIES];
  logic [1:0]       e_prot [ENTRIES];
  logic [ENTRIES-1:0] e_val, e_mod, match;

  logic [IDX_W-1:0] hit_idx, free_idx, rr_ptr, victim;
  logic any_hit, any_free, perm_ok, wr_ok;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = e_val[i] && (e_vpn[i] == lk_vpn) &&
                      (!PID_EN || (e_pid[i] == lk_pid));
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx  = IDX_W'(i);
      if (!e_val[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_hit  = |match;
  assign any_free = ~&e_val;
  assign victim   = any_free ? free_idx : rr_ptr;
  assign perm_ok  = lk_write ? e_prot[hit_idx][1] : e_prot[hit_idx][0];
  assign wr_ok    = lk_valid && lk_write && any_hit && perm_ok;

  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_vpn[victim]  <= fill_vpn;
      e_pfn[victim]  <= fill_pfn;
      e_pid[victim]  <= fill_pid;
      e_prot[victim] <= fill_prot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_val  <= '0;
      e_mod  <= '0;
      rr_ptr <= '0;
    end else begin
      if (flush_en)
        for (int i = 0; i < ENTRIES; i++)
          if (!flush_by_pid || (e_pid[i] == flush_pid)) e_val[i] <= 1'b0;
      if (wr_ok) e_mod[hit_idx] <= 1'b1;
      if (fill_en) begin
        e_val[victim] <= 1'b1;
        e_mod[victim] <= 1'b0;
        if (!any_free) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit && perm_ok;
      rsp_fault <= lk_valid && any_hit && !perm_ok;
      rsp_pfn   <= (lk_valid && any_hit && perm_ok) ? e_pfn[hit_idx] : '0;
      rsp_dirty <= (lk_valid && any_hit && perm_ok) ? e_mod[hit_idx] : 1'b0;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               fill_en,
  input logic               flush_en,
  input logic               flush_by_pid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [ENTRIES-1:0] e_val,
  input logic [IDX_W-1:0]   victim
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R1
  no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_fault));

  // R4
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  // R8
  flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !flush_by_pid && !fill_en) |=> (e_val == '0));

  // R10
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> e_val[$past(victim)]);
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fill_en(fill_en),
  .flush_en(flush_en), .flush_by_pid(flush_by_pid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .e_val(e_val), .victim(victim)
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int N = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, fill_en = 0, flush_en = 0, flush_by_pid = 0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0;
  logic [7:0] lk_pid = '0, fill_pid = '0, flush_pid = '0;
  logic [15:0] fill_pfn = '0;
  logic [1:0] fill_prot = '0;
  logic rsp_valid, rsp_hit, rsp_fault, rsp_dirty;
  logic [15:0] rsp_pfn;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xlat_cache #(.ENTRIES(N)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic look(string tag, logic [19:0] v, logic [7:0] p, logic w,
                      logic eh, logic ef, logic [15:0] epfn, logic ed);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_pid = p; lk_write = w;
    @(posedge clk); #1;
    lk_valid = 0; lk_write = 0;
    chk({tag, " valid"}, 32'(rsp_valid), 1);
    chk({tag, " hit"}, 32'(rsp_hit), 32'(eh));
    chk({tag, " fault"}, 32'(rsp_fault), 32'(ef));
    chk({tag, " pfn"}, 32'(rsp_pfn), 32'(epfn));
    chk({tag, " dirty"}, 32'(rsp_dirty), 32'(ed));
  endtask

  task automatic fill(logic [19:0] v, logic [7:0] p, logic [15:0] f, logic [1:0] pr);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_pid = p; fill_pfn = f; fill_prot = pr;
    @(posedge clk); #1;
    fill_en = 0;
  endtask

  task automatic flush(logic by_pid, logic [7:0] p);
    @(negedge clk);
    flush_en = 1; flush_by_pid = by_pid; flush_pid = p;
    @(posedge clk); #1;
    flush_en = 0; flush_by_pid = 0;
  endtask

  task automatic t_reset();
    chk("R11 rsp_valid", 32'(rsp_valid), 0);
    chk("R11 rsp_hit", 32'(rsp_hit), 0);
    look("R11 empty miss", 20'h5, 8'd1, 0, 0, 0, 16'h0, 0);
    @(posedge clk); #1;
    chk("R1 no request no response", 32'(rsp_valid), 0);
  endtask

  task automatic t_populate();
    for (int i = 0; i < N; i++)
      fill(20'(i), (i == 5) ? 8'd7 : 8'd1, 16'(16'h200 + i),
           (i == 3) ? 2'b01 : (i == 4) ? 2'b00 : 2'b11);
    look("R1 hit slot 10", 20'd10, 8'd1, 0, 1, 0, 16'h20A, 0);
    look("R1 hit last slot", 20'd63, 8'd1, 0, 1, 0, 16'h23F, 0);
    look("R2 absent page", 20'h999, 8'd1, 0, 0, 0, 16'h0, 0);
    look("R3 pid mismatch", 20'd10, 8'd2, 0, 0, 0, 16'h0, 0);
  endtask

  task automatic t_protect();
    look("R4 write to read-only", 20'd3, 8'd1, 1, 0, 1, 16'h0, 0);
    look("R4 read-only unchanged", 20'd3, 8'd1, 0, 1, 0, 16'h203, 0);
    look("R4 read no permission", 20'd4, 8'd1, 0, 0, 1, 16'h0, 0);
  endtask

  task automatic t_dirty();
    look("R5 first write", 20'd10, 8'd1, 1, 1, 0, 16'h20A, 0);
    look("R5 dirty seen", 20'd10, 8'd1, 0, 1, 0, 16'h20A, 1);
  endtask

  task automatic t_pid_flush();
    flush(1, 8'd7);
    look("R9 flushed pid gone", 20'd5, 8'd7, 0, 0, 0, 16'h0, 0);
    look("R9 other pid kept", 20'd6, 8'd1, 0, 1, 0, 16'h206, 0);
  endtask

  task automatic t_victims();
    fill(20'h100, 8'd1, 16'h500, 2'b11);
    look("R6 new in free slot", 20'h100, 8'd1, 0, 1, 0, 16'h500, 0);
    look("R6 slot 0 kept", 20'd0, 8'd1, 0, 1, 0, 16'h200, 0);
    fill(20'h101, 8'd1, 16'h501, 2'b11);
    look("R7 slot 0 evicted", 20'd0, 8'd1, 0, 0, 0, 16'h0, 0);
    look("R7 slot 1 kept", 20'd1, 8'd1, 0, 1, 0, 16'h201, 0);
    fill(20'h102, 8'd1, 16'h502, 2'b11);
    look("R7 slot 1 evicted", 20'd1, 8'd1, 0, 0, 0, 16'h0, 0);
    look("R7 slot 2 kept", 20'd2, 8'd1, 0, 1, 0, 16'h202, 0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    lk_valid = 1; lk_vpn = 20'd2; lk_pid = 8'd1; lk_write = 1;
    fill_en = 1; fill_vpn = 20'h103; fill_pid = 8'd1; fill_pfn = 16'h503; fill_prot = 2'b11;
    @(posedge clk); #1;
    lk_valid = 0; lk_write = 0; fill_en = 0;
    chk("R10 lookup sees old hit", 32'(rsp_hit), 1);
    chk("R10 lookup sees old pfn", 32'(rsp_pfn), 32'h202);
    look("R10 fill wins clean", 20'h103, 8'd1, 0, 1, 0, 16'h503, 0);
    look("R10 old page gone", 20'd2, 8'd1, 0, 0, 0, 16'h0, 0);
  endtask

  task automatic t_flush_all();
    flush(0, 8'd0);
    look("R8 flushed low", 20'd6, 8'd1, 0, 0, 0, 16'h0, 0);
    look("R8 flushed new", 20'h103, 8'd1, 0, 0, 0, 16'h0, 0);
    look("R8 flushed high", 20'd63, 8'd1, 0, 0, 0, 16'h0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_populate();
    t_protect();
    t_dirty();
    t_pid_flush();
    t_victims();
    t_collide();
    t_flush_all();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule